// File: doc/BRIEF.md
# Programmable Edge Combining Unit

This block watches a small group of synchronous digital lines and turns their edges into updates of either a signed 32-bit count or a single output bit. Each line can be marked as sensitive, as a modifier, or as both. A sensitive line's rising or falling edge triggers an action. The levels of the modifier lines choose which action that edge applies. The action comes from a per-line table of 2-bit codes, so one datapath can act as a follower, an inverter, an up counter, a direction-controlled up/down counter or a gated counter. Only the table contents change between these uses.

The tables and the two masks are loaded through a single write port. Edges are found by comparing each line with the value it had one clock earlier. The first sample after reset only primes that history and causes no action. A mode input selects the target. In count mode only the count changes. In bit mode only the output bit changes. A synchronous clear zeroes both the count and the bit.

Top module: `edge_combiner`

## Requirements
- R1: After reset, `acc_out` is 0, `bit_out` is 0 and `config_error` is 0. The first clock after reset records the line levels and acts on no edge.
- R2: In count mode (`mode`=0), an edge whose code is 01 adds 1 to `acc_out` and an edge whose code is 10 subtracts 1. The new value appears after the clock edge that samples the line change.
- R3: In bit mode (`mode`=1), code 01 sets `bit_out` and code 10 clears it, and `acc_out` holds. In count mode `bit_out` holds.
- R4: Codes 00 and 11 change neither output. Selecting code 11 sets `config_error`, which then stays set until reset, even through `clr`.
- R5: Writing `cfg_addr`=i (i < N_IN) loads the table of line i from `cfg_wdata[4*2^(N_IN-1)-1:0]`. Entry m occupies bits [4m+3:4m]: bits [4m+1:4m] hold the rising-edge code and bits [4m+3:4m+2] hold the falling-edge code.
- R6: For an edge on line i, the entry index m is built from the other lines in ascending index order, skipping i. Bit k of m is the level of the k-th such line if its modifier-mask bit is 1, and 0 otherwise.
- R7: Writing `cfg_addr`=N_IN loads the sensitive mask from `cfg_wdata[N_IN-1:0]` and the modifier mask from `cfg_wdata[2*N_IN-1:N_IN]`. Edges on lines whose sensitive bit is 0 have no effect.
- R8: `clr` zeroes `acc_out` and `bit_out` on the next clock and takes priority over an edge in the same cycle.
- R9: The count wraps modulo 2^32: decrementing 0 gives 0xFFFFFFFF.
- R10: If several sensitive lines change in the same cycle, only the lowest-indexed one acts.
- R11: A configuration write applies from the next cycle on. An edge sampled in the same cycle as the write uses the previous table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of count and bit |
| mode | input | 1 | 0 = update the count, 1 = update the bit |
| din | input | N_IN | Synchronous input lines |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | $clog2(N_IN+1) | Configuration word select: table 0..N_IN-1, masks at N_IN |
| cfg_wdata | input | max(4*2^(N_IN-1), 2*N_IN) | Configuration write data |
| acc_out | output | ACC_W | Signed count |
| bit_out | output | 1 | Output bit |
| config_error | output | 1 | Sticky flag: reserved code was selected |

## Verification
The hardest situations to reach are an edge that meets a change in another part of the block in the same cycle. Examples are an edge arriving with a table write, with `clr`, or with a second sensitive line changing, and an edge whose entry index depends on a line that is a modifier for one line but is masked off. The stimulus drives these collisions on purpose: it raises `cfg_we` together with a line change, raises `clr` together with an edge, and flips two sensitive lines in one cycle. It also rewrites the modifier mask between pulses while the other lines keep the same levels, so that only the mask decides which entry is used. A behavioural model computes the expected count, bit and error flag on every clock.

// File: rtl/edge_combiner_pkg.sv
package edge_combiner_pkg;

  localparam int unsigned MAX_N  = 3;
  localparam int unsigned MAX_FW = 16;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_UP   = 2'b01,
    ACT_DOWN = 2'b10,
    ACT_RSVD = 2'b11
  } act_e;

  // Entry index for an edge on line 'self': other lines packed in ascending order,
  // each gated by its modifier-mask bit.
  function automatic logic [1:0] mod_state(input logic [MAX_N-1:0] lvl,
                                           input logic [MAX_N-1:0] mmask,
                                           input int unsigned self,
                                           input int unsigned n);
    logic [1:0] ms;
    int unsigned k;
    ms = '0;
    k  = 0;
    for (int unsigned j = 0; j < MAX_N; j++) begin
      if (j < n && j != self) begin
        if (k < 2) ms[k] = lvl[j] & mmask[j];
        k++;
      end
    end
    return ms;
  endfunction

  // 2-bit code from a table: entry m at [4m+3:4m], rising in low pair, falling in high pair.
  function automatic logic [1:0] pick_code(input logic [MAX_FW-1:0] tab,
                                           input logic [1:0] ms,
                                           input logic falling);
    int unsigned pos;
    pos = 4 * int'(ms) + (falling ? 2 : 0);
    return tab[pos +: 2];
  endfunction

endpackage

// File: rtl/edge_combiner_edge.sv
module edge_combiner_edge #(
  parameter int unsigned N_IN = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] din,
  output logic [N_IN-1:0] rise,
  output logic [N_IN-1:0] fall
);

  logic [N_IN-1:0] din_q;
  logic            primed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      din_q  <= '0;
      primed <= 1'b0;
    end else begin
      din_q  <= din;
      primed <= 1'b1;
    end
  end

  assign rise = primed ? (din & ~din_q) : '0;
  assign fall = primed ? (~din & din_q) : '0;

endmodule

// File: rtl/edge_combiner_lut.sv
module edge_combiner_lut
  import edge_combiner_pkg::*;
#(
  parameter int unsigned N_IN  = 3,
  parameter int unsigned FW    = 4 * (1 << (N_IN - 1)),
  parameter int unsigned CFG_W = (FW > 2 * N_IN) ? FW : 2 * N_IN,
  parameter int unsigned AW    = $clog2(N_IN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic [N_IN-1:0]  din,
  input  logic [N_IN-1:0]  rise,
  input  logic [N_IN-1:0]  fall,
  output logic             ev_valid,
  output logic [1:0]       ev_code
);

  logic [N_IN-1:0]   sens_mask;
  logic [N_IN-1:0]   mod_mask;
  logic [N_IN-1:0]   cand;
  logic [2*N_IN-1:0] code_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sens_mask <= '0;
      mod_mask  <= '0;
    end else if (cfg_we && cfg_addr == AW'(N_IN)) begin
      sens_mask <= cfg_wdata[N_IN-1:0];
      mod_mask  <= cfg_wdata[2*N_IN-1:N_IN];
    end
  end

  for (genvar g = 0; g < N_IN; g++) begin : g_line
    logic [FW-1:0] tab;
    logic [1:0]    ms;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 tab <= '0;
      else if (cfg_we && cfg_addr == AW'(g))      tab <= cfg_wdata[FW-1:0];
    end

    assign ms                = mod_state(MAX_N'(din), MAX_N'(mod_mask), g, N_IN);
    assign cand[g]           = (rise[g] | fall[g]) & sens_mask[g];
    assign code_v[2*g +: 2]  = pick_code(MAX_FW'(tab), ms, fall[g]);
  end

  // Lowest-indexed changing sensitive line wins.
  always_comb begin
    ev_valid = 1'b0;
    ev_code  = 2'b00;
    for (int i = N_IN - 1; i >= 0; i--) begin
      if (cand[i]) begin
        ev_valid = 1'b1;
        ev_code  = code_v[2*i +: 2];
      end
    end
  end

endmodule

// File: rtl/edge_combiner_update.sv
module edge_combiner_update
  import edge_combiner_pkg::*;
#(
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             mode,
  input  logic             ev_valid,
  input  logic [1:0]       ev_code,
  output logic [ACC_W-1:0] acc_out,
  output logic             bit_out,
  output logic             config_error
);

  function automatic logic [ACC_W-1:0] step(input logic [ACC_W-1:0] a, input act_e c);
    case (c)
      ACT_UP:   return a + ACC_W'(1);
      ACT_DOWN: return a - ACC_W'(1);
      default:  return a;
    endcase
  endfunction

  function automatic logic level(input logic b, input act_e c);
    case (c)
      ACT_UP:   return 1'b1;
      ACT_DOWN: return 1'b0;
      default:  return b;
    endcase
  endfunction

  act_e code;
  assign code = act_e'(ev_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_out <= '0;
      bit_out <= 1'b0;
    end else if (clr) begin
      acc_out <= '0;
      bit_out <= 1'b0;
    end else if (ev_valid) begin
      if (mode) bit_out <= level(bit_out, code);
      else      acc_out <= step(acc_out, code);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            config_error <= 1'b0;
    else if (ev_valid && code == ACT_RSVD) config_error <= 1'b1;
  end

endmodule

// File: rtl/edge_combiner.sv
module edge_combiner #(
  parameter int unsigned N_IN  = 3,
  parameter int unsigned ACC_W = 32,
  localparam int unsigned FW    = 4 * (1 << (N_IN - 1)),
  localparam int unsigned CFG_W = (FW > 2 * N_IN) ? FW : 2 * N_IN,
  localparam int unsigned AW    = $clog2(N_IN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             mode,
  input  logic [N_IN-1:0]  din,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [ACC_W-1:0] acc_out,
  output logic             bit_out,
  output logic             config_error
);

  logic [N_IN-1:0] rise;
  logic [N_IN-1:0] fall;
  logic            ev_valid;
  logic [1:0]      ev_code;

  edge_combiner_edge #(.N_IN(N_IN)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (din),
    .rise (rise),
    .fall (fall)
  );

  edge_combiner_lut #(.N_IN(N_IN), .FW(FW), .CFG_W(CFG_W), .AW(AW)) u_lut (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .din      (din),
    .rise     (rise),
    .fall     (fall),
    .ev_valid (ev_valid),
    .ev_code  (ev_code)
  );

  edge_combiner_update #(.ACC_W(ACC_W)) u_upd (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (clr),
    .mode        (mode),
    .ev_valid    (ev_valid),
    .ev_code     (ev_code),
    .acc_out     (acc_out),
    .bit_out     (bit_out),
    .config_error(config_error)
  );

endmodule

// File: rtl/edge_combiner_chk.sv
module edge_combiner_chk #(
  parameter int unsigned ACC_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             mode,
  input logic             ev_valid,
  input logic [1:0]       ev_code,
  input logic [ACC_W-1:0] acc_out,
  input logic             bit_out,
  input logic             config_error
);

  AST_ACC_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && ev_valid && !mode && ev_code == 2'b01) |=> acc_out == $past(acc_out) + ACC_W'(1)); // R2
  AST_ACC_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && ev_valid && !mode && ev_code == 2'b10) |=> acc_out == $past(acc_out) - ACC_W'(1)); // R9
  AST_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && ev_valid && mode && ev_code == 2'b01) |=> bit_out); // R3
  AST_BIT_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && mode) |=> $stable(acc_out)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !ev_valid) |=> ($stable(acc_out) && $stable(bit_out))); // R7
  AST_RSVD_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && ev_valid && ev_code == 2'b11) |=> ($stable(acc_out) && $stable(bit_out) && config_error)); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    config_error |=> config_error); // R4
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_out == '0 && !bit_out)); // R8

endmodule

bind edge_combiner edge_combiner_chk #(.ACC_W(ACC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clr         (clr),
  .mode        (mode),
  .ev_valid    (ev_valid),
  .ev_code     (ev_code),
  .acc_out     (acc_out),
  .bit_out     (bit_out),
  .config_error(config_error)
);

// File: tb/edge_combiner_tb.sv
module edge_combiner_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 3;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        clr = 0;
  logic        mode = 0;
  logic [2:0]  din = 0;
  logic        cfg_we = 0;
  logic [1:0]  cfg_addr = 0;
  logic [15:0] cfg_wdata = 0;
  logic [31:0] acc_out;
  logic        bit_out;
  logic        config_error;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  edge_combiner u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .mode(mode), .din(din),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .acc_out(acc_out), .bit_out(bit_out), .config_error(config_error)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  logic [15:0] m_tab [N];
  logic [2:0]  m_sens, m_mod, m_prev;
  bit          m_primed;
  logic [31:0] m_acc;
  bit          m_bit, m_err;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) m_tab[i] = 0;
      m_sens = 0; m_mod = 0; m_prev = 0; m_primed = 0;
      m_acc = 0; m_bit = 0; m_err = 0;
    end else begin
      int hit, ms, k, code;
      hit = -1;
      if (m_primed)
        for (int i = 0; i < N; i++)
          if (hit < 0 && din[i] != m_prev[i] && m_sens[i]) hit = i;
      if (hit >= 0) begin
        ms = 0; k = 0;
        for (int j = 0; j < N; j++)
          if (j != hit) begin
            if (m_mod[j] && din[j]) ms += (1 << k);
            k++;
          end
        code = (m_tab[hit] >> (4 * ms + (din[hit] ? 0 : 2))) & 3;
        if (code == 3) m_err = 1;
        if (mode) begin
          if (code == 1) m_bit = 1;
          else if (code == 2) m_bit = 0;
        end else begin
          if (code == 1) m_acc = m_acc + 1;
          else if (code == 2) m_acc = m_acc - 1;
        end
      end
      if (clr) begin m_acc = 0; m_bit = 0; end
      if (cfg_we) begin
        if (cfg_addr < N) m_tab[cfg_addr] = cfg_wdata;
        else begin m_sens = cfg_wdata[2:0]; m_mod = cfg_wdata[5:3]; end
      end
      m_prev = din; m_primed = 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    check("R2 model acc", acc_out, m_acc);
    check("R3 model bit", 32'(bit_out), 32'(m_bit));
    check("R4 model err", 32'(config_error), 32'(m_err));
  end

  task automatic tick(); @(negedge clk); #1; endtask
  task automatic wcfg(input logic [1:0] a, input logic [15:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d; tick(); cfg_we = 0;
  endtask
  task automatic pulse(input int i);
    din[i] = 1; tick(); din[i] = 0; tick();
  endtask
  task automatic do_clr(); clr = 1; tick(); clr = 0; endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] a0;
    din = 3'b001;
    repeat (3) tick();
    check("R1 reset acc", acc_out, 0);
    check("R1 reset bit", 32'(bit_out), 0);
    check("R1 reset err", 32'(config_error), 0);
    rst_n = 1; tick(); tick();
    check("R1 no action on first sample", acc_out, 0);
    din = 0; tick();

    // Up counter on line 0 (R5, R2)
    wcfg(0, 16'h1111); wcfg(3, 16'h0001);
    for (int p = 0; p < 5; p++) pulse(0);
    check("R2 up count", acc_out, 5);

    // Follower and inverter in bit mode (R3)
    mode = 1; wcfg(0, 16'h9999);
    din[0] = 1; tick();
    check("R3 follower set", 32'(bit_out), 1);
    check("R3 acc held in bit mode", acc_out, 5);
    din[0] = 0; tick();
    check("R3 follower clear", 32'(bit_out), 0);
    wcfg(0, 16'h6666);
    din[0] = 1; tick();
    check("R3 inverter rise", 32'(bit_out), 0);
    din[0] = 0; tick();
    check("R3 inverter fall", 32'(bit_out), 1);
    mode = 0;

    // Modifier-selected direction (R6, R7, R8)
    do_clr();
    check("R8 clear acc", acc_out, 0);
    check("R8 clear bit", 32'(bit_out), 0);
    wcfg(0, 16'h0021); wcfg(3, 16'h0011);
    for (int p = 0; p < 3; p++) pulse(0);
    check("R6 entry 0 counts up", acc_out, 3);
    din[1] = 1; tick();
    check("R7 non-sensitive edge ignored", acc_out, 3);
    pulse(0);
    check("R6 entry 1 counts down", acc_out, 2);
    din[2] = 1; tick();
    pulse(0);
    check("R6 unmasked modifier ignored", acc_out, 1);
    wcfg(3, 16'h0031);
    pulse(0);
    check("R6 entry 3 code 00 ignored", acc_out, 1);

    // Wrap (R9)
    wcfg(3, 16'h0011);
    do_clr();
    pulse(0);
    check("R9 wrap below zero", acc_out, 32'hFFFF_FFFF);

    // Clear beats edge (R8)
    din[0] = 1; clr = 1; tick(); clr = 0;
    check("R8 clear priority", acc_out, 0);
    din[0] = 0; tick();

    // Reserved code (R4)
    wcfg(0, 16'h3333);
    pulse(0);
    check("R4 reserved no change", acc_out, 0);
    check("R4 reserved flags error", 32'(config_error), 1);
    do_clr();
    check("R4 error sticky through clr", 32'(config_error), 1);

    // Simultaneous edges (R10)
    din = 0; tick();
    wcfg(0, 16'h1111); wcfg(1, 16'h2222); wcfg(3, 16'h0003);
    a0 = acc_out;
    din = 3'b011; tick();
    check("R10 lowest index wins", acc_out, a0 + 1);
    din = 0; tick();
    check("R10 falling code 00", acc_out, a0 + 1);

    // Write and edge in the same cycle (R11)
    din[0] = 1; cfg_we = 1; cfg_addr = 0; cfg_wdata = 16'h2222; tick(); cfg_we = 0;
    check("R11 old table used", acc_out, a0 + 2);
    din[0] = 0; tick();
    din[0] = 1; tick();
    check("R11 new table applied", acc_out, a0 + 1);
    din[0] = 0; tick();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule